// File: doc/BRIEF.md
# Multi-Rail Reset Supervisor Controller

This controller is the digital half of a supply supervisor. It receives logic-level comparator results for one main supply and a set of auxiliary rails, together with an active-low manual-reset button input. From these it produces a system reset that is held after the supply is good and the button is released, one fail flag per auxiliary rail, and an early warning that tracks the main supply with no delay.

All comparator inputs and the button pass through two-flop synchronizers. The button is also debounced. A small state machine times the release. Its states are `ST_HOLD` (reset held, waiting for conditions), `ST_COUNT` (conditions good, hold timer running) and `ST_RUN` (reset released). Its transitions are:

- `T_GO` (`ST_HOLD` to `ST_COUNT`): the synchronized main supply is good and the debounced button is released.
- `T_ABORT` (`ST_COUNT` to `ST_HOLD`): either condition is lost, which discards the count.
- `T_DONE` (`ST_COUNT` to `ST_RUN`): the hold time has elapsed.
- `T_FAULT` (`ST_RUN` to `ST_HOLD`): either condition is lost.

Each auxiliary fail flag can also be folded into the reset by a per-rail merge input. A parameter sets the reset polarity.

Top module: `rail_supervisor`

## Requirements
- R1: While `rst_n` is low, the reset output is asserted, every `aux_fail` bit is 1 and `early_warn_n` is 0. This holds whatever the input levels are.
- R2: With the button released and debounced, reset releases exactly D+3 clock edges after `main_ok` rises. These are 2 synchronizer edges, 1 edge for `T_GO` and D counting edges.
- R3: The hold time is D = HOLD_BASE × 4^`hold_sel`, so codes 0, 1, 2 and 3 give 1, 4, 16 and 64 times HOLD_BASE. `hold_sel` is sampled on the `T_GO` edge, and a change during the count has no effect.
- R4: A button press (`mr_n` low) that lasts DEB_CYC cycles or more asserts reset DEB_CYC+3 edges after it starts. After the button is released, reset releases DEB_CYC+D+3 edges later.
- R5: A low pulse on `mr_n` shorter than DEB_CYC cycles has no effect on the reset output.
- R6: A drop of `main_ok` asserts reset 2 edges later, through the synchronizer only and without waiting for the state machine.
- R7: Any loss of the main supply during the count restarts it. After recovery, reset releases a full D+3 edges later.
- R8: `aux_fail[i]` equals the inverse of `aux_ok[i]`, delayed by 2 edges, with no hold timer in either direction.
- R9: When `merge_aux[i]` is 1, a set `aux_fail[i]` also asserts the reset. When `merge_aux[i]` is 0, the flag leaves the reset untouched.
- R10: `early_warn_n` follows `main_ok` 2 edges later, in both directions, with no hold timer. Whenever it is low, the reset is asserted.
- R11: With RST_ACTIVE_HIGH = 1 the asserted reset level is 1. With RST_ACTIVE_HIGH = 0 it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low controller reset |
| main_ok | input | 1 | 1 when the main supply is above its threshold |
| aux_ok | input | AUX_N | 1 per rail when that auxiliary rail is above its threshold |
| mr_n | input | 1 | Manual reset button, low while pressed |
| hold_sel | input | 2 | Hold time code (see R3) |
| merge_aux | input | AUX_N | Per-rail enable that folds the fail flag into reset |
| sys_rst | output | 1 | System reset, polarity set by RST_ACTIVE_HIGH |
| aux_fail | output | AUX_N | Per-rail fail flag, 1 = rail low |
| early_warn_n | output | 1 | Undelayed low-supply warning, 0 = main supply low |

## Verification
The bench builds the block with HOLD_BASE = 4 and DEB_CYC = 3. This makes all four hold codes (4, 16, 64 and 256 cycles) short enough to measure edge-exact, including a mid-count change of `hold_sel`. The small debounce length lets a 2-cycle button pulse be shown to be ignored while a 3-cycle press is honoured. A second instance built with RST_ACTIVE_HIGH = 1 shares every input, so each reset check also confirms that the two polarities are exact inverses.

// File: rtl/rsup_pkg.sv
package rsup_pkg;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_COUNT = 2'd1,
        ST_RUN   = 2'd2
    } hold_state_t;

    // Hold length in cycles for a given code: base * 4^sel
    function automatic int hold_cycles(input int base, input logic [1:0] sel);
        return base << (2 * int'(sel));
    endfunction

endpackage

// File: rtl/rsup_sync.sv
module rsup_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Reset to zero: every input reads as "bad / pressed" until sampled
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/rsup_debounce.sv
module rsup_debounce #(
    parameter int DEB_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic stable
);
    localparam int CW = $clog2(DEB_CYC + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            stable <= 1'b0;
        end else if (raw == stable) begin
            cnt_q <= '0;
        end else if (cnt_q == CW'(DEB_CYC - 1)) begin
            cnt_q  <= '0;
            stable <= raw;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/rsup_hold_fsm.sv
module rsup_hold_fsm
    import rsup_pkg::*;
#(
    parameter int HOLD_BASE = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       main_s,
    input  logic       mr_db,
    input  logic [1:0] hold_sel,
    output logic       released,
    output logic       counting
);
    localparam int CNT_W = $clog2(HOLD_BASE * 64 + 1);

    hold_state_t      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] target_q;
    logic             cond_ok;

    assign cond_ok = main_s && mr_db;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:  if (cond_ok) state_d = ST_COUNT;                    // T_GO
            ST_COUNT: if (!cond_ok) state_d = ST_HOLD;                    // T_ABORT
                      else if (cnt_q == target_q - 1'b1) state_d = ST_RUN; // T_DONE
            ST_RUN:   if (!cond_ok) state_d = ST_HOLD;                    // T_FAULT
            default:  state_d = ST_HOLD;
        endcase
    end

    // Hold timer: target follows the code while holding, frozen once counting
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            target_q <= CNT_W'(hold_cycles(HOLD_BASE, 2'd0));
        end else if (state_q == ST_COUNT) begin
            cnt_q <= cnt_q + 1'b1;
        end else begin
            cnt_q    <= '0;
            target_q <= CNT_W'(hold_cycles(HOLD_BASE, hold_sel));
        end
    end

    // Outputs
    always_comb begin
        released = 1'b0;
        counting = 1'b0;
        unique case (state_q)
            ST_HOLD:  ;
            ST_COUNT: counting = 1'b1;
            ST_RUN:   released = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/rail_supervisor.sv
module rail_supervisor #(
    parameter int AUX_N           = 2,
    parameter int HOLD_BASE       = 1000,
    parameter int DEB_CYC         = 8,
    parameter bit RST_ACTIVE_HIGH = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             main_ok,
    input  logic [AUX_N-1:0] aux_ok,
    input  logic             mr_n,
    input  logic [1:0]       hold_sel,
    input  logic [AUX_N-1:0] merge_aux,
    output logic             sys_rst,
    output logic [AUX_N-1:0] aux_fail,
    output logic             early_warn_n
);
    localparam int SYNC_W = AUX_N + 2;

    logic [SYNC_W-1:0] sync_q;
    logic              main_s;
    logic [AUX_N-1:0]  aux_s;
    logic              mr_s;
    logic              mr_db;
    logic              released;
    logic              counting;
    logic [AUX_N-1:0]  merged;
    logic              rst_active;

    rsup_sync #(.W(SYNC_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({mr_n, aux_ok, main_ok}),
        .q     (sync_q)
    );

    assign main_s = sync_q[0];
    assign aux_s  = sync_q[AUX_N:1];
    assign mr_s   = sync_q[SYNC_W-1];

    rsup_debounce #(.DEB_CYC(DEB_CYC)) u_deb (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (mr_s),
        .stable (mr_db)
    );

    rsup_hold_fsm #(.HOLD_BASE(HOLD_BASE)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .main_s   (main_s),
        .mr_db    (mr_db),
        .hold_sel (hold_sel),
        .released (released),
        .counting (counting)
    );

    for (genvar i = 0; i < AUX_N; i++) begin : g_rail
        assign aux_fail[i] = !aux_s[i];
        assign merged[i]   = merge_aux[i] && !aux_s[i];
    end

    assign early_warn_n = main_s;
    assign rst_active   = !released || !main_s || (|merged);

    if (RST_ACTIVE_HIGH) begin : g_pol_hi
        assign sys_rst = rst_active;
    end else begin : g_pol_lo
        assign sys_rst = !rst_active;
    end
endmodule

// File: rtl/rsup_chk.sv
module rsup_chk #(
    parameter int AUX_N = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             main_s,
    input logic             mr_s,
    input logic             mr_db,
    input logic             released,
    input logic             counting,
    input logic             rst_active,
    input logic             early_warn_n,
    input logic [AUX_N-1:0] aux_fail,
    input logic [AUX_N-1:0] merge_aux
);
    // R2
    rel_needs_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
        released |-> $past(main_s));

    // R4
    rel_needs_button_chk: assert property (@(posedge clk) disable iff (!rst_n)
        released |-> $past(mr_db));

    // R7
    rel_from_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(released) |-> $past(counting));

    // R5
    deb_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mr_db != $past(mr_db)) |-> (mr_db == $past(mr_s)));

    // R10
    warn_implies_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !early_warn_n |-> rst_active);

    // R9
    merge_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(merge_aux & aux_fail)) |-> rst_active);
endmodule

bind rail_supervisor rsup_chk #(.AUX_N(AUX_N)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .main_s       (main_s),
    .mr_s         (mr_s),
    .mr_db        (mr_db),
    .released     (released),
    .counting     (counting),
    .rst_active   (rst_active),
    .early_warn_n (early_warn_n),
    .aux_fail     (aux_fail),
    .merge_aux    (merge_aux)
);

// File: tb/test_rail_supervisor.sv
`timescale 1ns/1ps
module test_rail_supervisor;
    localparam int BASE = 4;
    localparam int DEB  = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       main_ok = 1'b1;
    logic [1:0] aux_ok = 2'b11;
    logic       mr_n = 1'b1;
    logic [1:0] hold_sel = 2'd0;
    logic [1:0] merge_aux = 2'b00;
    logic       sys_rst, sys_rst_h;
    logic [1:0] aux_fail, aux_fail_h;
    logic       early_warn_n, early_warn_h;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;   // 125 MHz

    rail_supervisor #(.AUX_N(2), .HOLD_BASE(BASE), .DEB_CYC(DEB), .RST_ACTIVE_HIGH(1'b0))
    i_rail_supervisor (
        .clk(clk), .rst_n(rst_n), .main_ok(main_ok), .aux_ok(aux_ok), .mr_n(mr_n),
        .hold_sel(hold_sel), .merge_aux(merge_aux), .sys_rst(sys_rst),
        .aux_fail(aux_fail), .early_warn_n(early_warn_n)
    );

    rail_supervisor #(.AUX_N(2), .HOLD_BASE(BASE), .DEB_CYC(DEB), .RST_ACTIVE_HIGH(1'b1))
    i_rail_supervisor_pol (
        .clk(clk), .rst_n(rst_n), .main_ok(main_ok), .aux_ok(aux_ok), .mr_n(mr_n),
        .hold_sel(hold_sel), .merge_aux(merge_aux), .sys_rst(sys_rst_h),
        .aux_fail(aux_fail_h), .early_warn_n(early_warn_h)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // exp_on: 1 = reset expected asserted; also cross-checks polarity (R11)
    task automatic chk_rst(input string req, input int exp_on);
        int act;
        act = (sys_rst == 1'b0) ? 1 : 0;
        check(act == exp_on, req, act, exp_on);
        check(sys_rst_h == !sys_rst, "R11", int'(sys_rst_h), int'(!sys_rst));
    endtask

    task automatic expect_release(input string req, input int total);
        edges(total - 1);
        chk_rst(req, 1);
        edges(1);
        chk_rst(req, 0);
    endtask

    task automatic t_reset;
        #20;
        chk_rst("R1", 1);
        check(aux_fail == 2'b11, "R1", int'(aux_fail), 3);
        check(early_warn_n == 1'b0, "R1", int'(early_warn_n), 0);
        @(negedge clk) rst_n = 1'b1;
        expect_release("R1", DEB + BASE + 3);
    endtask

    task automatic t_powerup;
        @(negedge clk);
        rst_n = 1'b0; main_ok = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        edges(12);
        chk_rst("R2", 1);
        check(early_warn_n == 1'b0, "R10", int'(early_warn_n), 0);
        check(aux_fail == 2'b00, "R8", int'(aux_fail), 0);
        @(negedge clk) main_ok = 1'b1;
        edges(2);
        check(early_warn_n == 1'b1, "R10", int'(early_warn_n), 1);
        expect_release("R2", BASE + 1);
    endtask

    task automatic t_sel;
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            main_ok = 1'b0; hold_sel = 2'(s);
            edges(3);
            @(negedge clk) main_ok = 1'b1;
            expect_release("R3", (BASE << (2 * s)) + 3);
        end
        // code changed after counting began: ignored
        @(negedge clk);
        main_ok = 1'b0; hold_sel = 2'd0;
        edges(3);
        @(negedge clk) main_ok = 1'b1;
        edges(3);
        @(negedge clk) hold_sel = 2'd3;
        expect_release("R3", BASE);
        @(negedge clk) hold_sel = 2'd0;
    endtask

    task automatic t_drop;
        @(negedge clk) main_ok = 1'b0;
        edges(1);
        chk_rst("R6", 0);
        check(early_warn_n == 1'b1, "R10", int'(early_warn_n), 1);
        edges(1);
        chk_rst("R6", 1);
        check(early_warn_n == 1'b0, "R10", int'(early_warn_n), 0);
        @(negedge clk) main_ok = 1'b1;
        edges(1);
        check(early_warn_n == 1'b0, "R10", int'(early_warn_n), 0);
        edges(1);
        check(early_warn_n == 1'b1, "R10", int'(early_warn_n), 1);
        chk_rst("R6", 1);
        expect_release("R6", BASE + 1);
    endtask

    task automatic t_glitch;
        @(negedge clk);
        main_ok = 1'b0; hold_sel = 2'd1;
        edges(3);
        @(negedge clk) main_ok = 1'b1;
        edges(8);
        @(negedge clk) main_ok = 1'b0;
        @(negedge clk);
        @(negedge clk) main_ok = 1'b1;
        edges(10);
        chk_rst("R7", 1);   // an unrestarted count would have released by now
        expect_release("R7", (BASE * 4) + 3 - 10);
        @(negedge clk) hold_sel = 2'd0;
    endtask

    task automatic t_mr;
        @(negedge clk) mr_n = 1'b0;
        edges(DEB + 2);
        chk_rst("R4", 0);
        edges(1);
        chk_rst("R4", 1);
        edges(10);
        chk_rst("R4", 1);
        @(negedge clk) mr_n = 1'b1;
        expect_release("R4", DEB + BASE + 3);
    endtask

    task automatic t_bounce;
        @(negedge clk) mr_n = 1'b0;
        @(negedge clk);
        @(negedge clk) mr_n = 1'b1;
        for (int k = 0; k < 12; k++) begin
            edges(1);
            chk_rst("R5", 0);
        end
    endtask

    task automatic t_aux;
        @(negedge clk);
        merge_aux = 2'b00; aux_ok[0] = 1'b0;
        edges(1);
        check(aux_fail[0] == 1'b0, "R8", int'(aux_fail[0]), 0);
        edges(1);
        check(aux_fail[0] == 1'b1, "R8", int'(aux_fail[0]), 1);
        chk_rst("R9", 0);
        @(negedge clk) aux_ok[0] = 1'b1;
        edges(2);
        check(aux_fail[0] == 1'b0, "R8", int'(aux_fail[0]), 0);
        @(negedge clk) merge_aux = 2'b10;
        @(negedge clk) aux_ok[1] = 1'b0;
        edges(1);
        chk_rst("R9", 0);
        edges(1);
        chk_rst("R9", 1);
        check(aux_fail[1] == 1'b1, "R8", int'(aux_fail[1]), 1);
        @(negedge clk) aux_ok[1] = 1'b1;
        edges(2);
        chk_rst("R9", 0);
        check(aux_fail[1] == 1'b0, "R8", int'(aux_fail[1]), 0);
        @(negedge clk) merge_aux = 2'b00;
    endtask

    initial begin
        t_reset();
        t_powerup();
        t_sel();
        t_drop();
        t_glitch();
        t_mr();
        t_bounce();
        t_aux();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule